// File: doc/BRIEF.md
# Register Rename Status Table

This block tracks, for every architectural register of an out-of-order core, whether the register holds a committed value or is waiting on an in-flight producer identified by a tag. At dispatch the table answers two source lookups at once. Each answer is either a ready value or the pending tag that a reservation station must wait for. In the same cycle the table records the dispatched instruction's tag as the newest producer of its destination register.

The table watches the result broadcast bus. It writes a broadcast value into a register only while that register still names the broadcasting tag. A result from an older writer whose register has since been renamed is therefore dropped, which removes write-after-write hazards. A flush returns every register to the ready state, holding its last written value.

The dispatch side is a valid/ready stream. The table lowers `disp_ready` only while `flush` is high, and a dispatch counts only when both `disp_valid` and `disp_ready` are high. The source lookup outputs are combinational from the source indices and carry no handshake. The broadcast bus cannot be stalled: a beat with `bc_valid` high is consumed in that cycle or discarded.

Top module: `rst_table`

## Requirements
- R1: After reset every register reads as ready, with value 0 and reported tag 0.
- R2: A lookup of a ready register returns ready=1, the stored value and tag 0, in the same cycle.
- R3: An accepted dispatch with `disp_dst_we`=1 makes the destination register pending on `disp_tag` from the next cycle. A lookup of that register then returns ready=0, value 0 and that tag.
- R4: A broadcast whose tag equals a pending register's tag writes `bc_data` into that register and marks it ready from the next cycle.
- R5: A broadcast whose tag differs from a pending register's current tag leaves that register's value, tag and pending state unchanged.
- R6: A lookup of a pending register in the same cycle as a matching broadcast returns ready=1 and the broadcast data.
- R7: The source lookups of a dispatch see the mapping from before that dispatch renames its own destination, even when a source equals the destination.
- R8: While `flush` is high, `disp_ready` is 0, broadcasts and dispatches have no effect, and lookups see no broadcast bypass. From the next cycle every register is ready and holds its last written value.
- R9: A dispatch with `disp_dst_we`=0, or with the write enable set but `disp_valid`=0, changes no register.
- R10: When a register is renamed in the same cycle that a broadcast matches its old tag, the rename wins. The register stays pending on the new tag, and the broadcast value is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Returns all registers to ready |
| disp_valid | input | 1 | Dispatch beat valid |
| disp_ready | output | 1 | Dispatch accepted (low during flush) |
| disp_src1 | input | IDX_W (3) | First source register index |
| disp_src2 | input | IDX_W (3) | Second source register index |
| disp_dst_we | input | 1 | Dispatch writes a destination |
| disp_dst | input | IDX_W (3) | Destination register index |
| disp_tag | input | TAG_W (4) | Tag of the dispatched instruction |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W (4) | Tag of the broadcast result |
| bc_data | input | DATA_W (16) | Broadcast result value |
| src1_ready | output | 1 | First source is available |
| src1_value | output | DATA_W (16) | First source value when ready, else 0 |
| src1_tag | output | TAG_W (4) | First source pending tag, 0 when ready |
| src2_ready | output | 1 | Second source is available |
| src2_value | output | DATA_W (16) | Second source value when ready, else 0 |
| src2_tag | output | TAG_W (4) | Second source pending tag, 0 when ready |

## Verification
The bench targets a stale broadcast arriving after a register was renamed. A table that ignored tag matching would overwrite the value with an old result and wrongly report the register ready. It drives a dispatch that reads and renames the same register. A table that applied the rename first would hand the instruction its own tag and deadlock it. It also checks same-cycle lookup and broadcast, where a missing bypass leaves the consumer waiting on a tag already broadcast. It puts a rename and a matching old-tag broadcast in one cycle, where the wrong priority drops the new producer. Last, it sends broadcasts and dispatches during a flush; a table that let either through would leave a register pending or corrupted after the flush.

// File: rtl/rst_pkg.sv
package rst_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_RENAME = 2'd1,
    UPD_WRITE  = 2'd2,
    UPD_FLUSH  = 2'd3
  } upd_e;

endpackage

// File: rtl/rst_entry.sv
module rst_entry
  import rst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              rdy,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] val
);

  upd_e upd;

  // priority: flush, then rename, then a broadcast naming the current tag
  always_comb begin
    if (flush)                                 upd = UPD_FLUSH;
    else if (ren_hit)                          upd = UPD_RENAME;
    else if (bc_valid && !rdy && tag == bc_tag) upd = UPD_WRITE;
    else                                       upd = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b1;
      tag <= '0;
      val <= '0;
    end else begin
      unique case (upd)
        UPD_FLUSH: begin
          rdy <= 1'b1;
          tag <= '0;
        end
        UPD_RENAME: begin
          rdy <= 1'b0;
          tag <= new_tag;
        end
        UPD_WRITE: begin
          rdy <= 1'b1;
          tag <= '0;
          val <= bc_data;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rst_lookup.sv
module rst_lookup #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                 src,
  input  logic [NUM_REGS-1:0]              rdy_vec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_vec,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_vec,
  input  logic                             bc_live,
  input  logic [TAG_W-1:0]                 bc_tag,
  input  logic [DATA_W-1:0]                bc_data,
  output logic                             ready,
  output logic [DATA_W-1:0]                value,
  output logic [TAG_W-1:0]                 tag
);

  logic hit_rdy;
  logic hit_bc;

  always_comb begin
    hit_rdy = rdy_vec[src];
    hit_bc  = !hit_rdy && bc_live && (tag_vec[src] == bc_tag);
    ready   = hit_rdy || hit_bc;
    if (hit_rdy)     value = val_vec[src];
    else if (hit_bc) value = bc_data;
    else             value = '0;
    tag = ready ? '0 : tag_vec[src];
  end

endmodule

// File: rtl/rst_table.sv
module rst_table #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [IDX_W-1:0]  disp_src1,
  input  logic [IDX_W-1:0]  disp_src2,
  input  logic              disp_dst_we,
  input  logic [IDX_W-1:0]  disp_dst,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              src1_ready,
  output logic [DATA_W-1:0] src1_value,
  output logic [TAG_W-1:0]  src1_tag,
  output logic              src2_ready,
  output logic [DATA_W-1:0] src2_value,
  output logic [TAG_W-1:0]  src2_tag
);

  logic                            fire;
  logic                            bc_live;
  logic [NUM_REGS-1:0]             rdy_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_vec;

  assign disp_ready = !flush;
  assign fire       = disp_valid && disp_ready && disp_dst_we;
  assign bc_live    = bc_valid && !flush;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic ren_hit;
    assign ren_hit = fire && (disp_dst == IDX_W'(g));

    rst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .ren_hit  (ren_hit),
      .new_tag  (disp_tag),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .rdy      (rdy_vec[g]),
      .tag      (tag_vec[g]),
      .val      (val_vec[g])
    );
  end

  rst_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look1 (
    .src     (disp_src1),
    .rdy_vec (rdy_vec),
    .tag_vec (tag_vec),
    .val_vec (val_vec),
    .bc_live (bc_live),
    .bc_tag  (bc_tag),
    .bc_data (bc_data),
    .ready   (src1_ready),
    .value   (src1_value),
    .tag     (src1_tag)
  );

  rst_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look2 (
    .src     (disp_src2),
    .rdy_vec (rdy_vec),
    .tag_vec (tag_vec),
    .val_vec (val_vec),
    .bc_live (bc_live),
    .bc_tag  (bc_tag),
    .bc_data (bc_data),
    .ready   (src2_ready),
    .value   (src2_value),
    .tag     (src2_tag)
  );

endmodule

// File: rtl/rst_table_chk.sv
module rst_table_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic                            disp_valid,
  input logic                            disp_ready,
  input logic [IDX_W-1:0]                disp_src1,
  input logic                            disp_dst_we,
  input logic [IDX_W-1:0]                disp_dst,
  input logic [TAG_W-1:0]                disp_tag,
  input logic                            bc_valid,
  input logic [TAG_W-1:0]                bc_tag,
  input logic [DATA_W-1:0]               bc_data,
  input logic                            src1_ready,
  input logic [DATA_W-1:0]               src1_value,
  input logic [NUM_REGS-1:0]             rdy_vec,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec,
  input logic [NUM_REGS-1:0][DATA_W-1:0] val_vec
);

  logic ren_src1;
  assign ren_src1 = disp_valid && disp_ready && disp_dst_we && (disp_dst == disp_src1);

  p_ready_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_vec[disp_src1] |-> (src1_ready && src1_value == val_vec[disp_src1]));

  p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_dst_we) |=>
      (!rdy_vec[$past(disp_dst)] && tag_vec[$past(disp_dst)] == $past(disp_tag)));

  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !flush && !ren_src1 && !rdy_vec[disp_src1] && tag_vec[disp_src1] == bc_tag) |=>
      (rdy_vec[$past(disp_src1)] && val_vec[$past(disp_src1)] == $past(bc_data)));

  p_stale_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !flush && !ren_src1 && !rdy_vec[disp_src1] && tag_vec[disp_src1] != bc_tag) |=>
      (!rdy_vec[$past(disp_src1)] && val_vec[$past(disp_src1)] == $past(val_vec[disp_src1])));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !flush && !rdy_vec[disp_src1] && tag_vec[disp_src1] == bc_tag) |->
      (src1_ready && src1_value == bc_data));

  p_flush_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&rdy_vec && val_vec == $past(val_vec)));

endmodule

bind rst_table rst_table_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .disp_src1   (disp_src1),
  .disp_dst_we (disp_dst_we),
  .disp_dst    (disp_dst),
  .disp_tag    (disp_tag),
  .bc_valid    (bc_valid),
  .bc_tag      (bc_tag),
  .bc_data     (bc_data),
  .src1_ready  (src1_ready),
  .src1_value  (src1_value),
  .rdy_vec     (rdy_vec),
  .tag_vec     (tag_vec),
  .val_vec     (val_vec)
);

// File: tb/rst_table_tb.sv
module rst_table_tb;

  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          disp_valid = 1'b0;
  logic          disp_ready;
  logic [IW-1:0] disp_src1 = '0;
  logic [IW-1:0] disp_src2 = '0;
  logic          disp_dst_we = 1'b0;
  logic [IW-1:0] disp_dst = '0;
  logic [TW-1:0] disp_tag = '0;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic          src1_ready, src2_ready;
  logic [DW-1:0] src1_value, src2_value;
  logic [TW-1:0] src1_tag, src2_tag;

  always #2 clk = ~clk;

  rst_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src1(disp_src1), .disp_src2(disp_src2),
    .disp_dst_we(disp_dst_we), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src1_ready(src1_ready), .src1_value(src1_value), .src1_tag(src1_tag),
    .src2_ready(src2_ready), .src2_value(src2_value), .src2_tag(src2_tag)
  );

  typedef struct {
    int            req;
    logic          dr;
    logic          r1;
    logic [DW-1:0] v1;
    logic [TW-1:0] t1;
    logic          r2;
    logic [DW-1:0] v2;
    logic [TW-1:0] t2;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // driver: apply one cycle of stimulus and queue the expected lookup answer
  task automatic step(input int req, input logic dv, input logic we, input int dst,
                      input int tg, input int s1, input int s2, input logic bv,
                      input int bt, input int bd, input logic fl, input logic dr,
                      input logic r1, input int v1, input int t1,
                      input logic r2, input int v2, input int t2);
    exp_t e;
    @(negedge clk);
    disp_valid  = dv;
    disp_dst_we = we;
    disp_dst    = IW'(dst);
    disp_tag    = TW'(tg);
    disp_src1   = IW'(s1);
    disp_src2   = IW'(s2);
    bc_valid    = bv;
    bc_tag      = TW'(bt);
    bc_data     = DW'(bd);
    flush       = fl;
    e.req = req; e.dr = dr;
    e.r1 = r1; e.v1 = DW'(v1); e.t1 = TW'(t1);
    e.r2 = r2; e.v2 = DW'(v2); e.t2 = TW'(t2);
    q.push_back(e);
  endtask

  // monitor: sample between the driving edge and the next active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (disp_ready !== e.dr || src1_ready !== e.r1 || src1_value !== e.v1 ||
            src1_tag !== e.t1 || src2_ready !== e.r2 || src2_value !== e.v2 ||
            src2_tag !== e.t2) begin
          errors++;
          $display("FAIL R%0d: got dr=%b s1=%b/%h/%h s2=%b/%h/%h exp dr=%b s1=%b/%h/%h s2=%b/%h/%h",
                   e.req, disp_ready, src1_ready, src1_value, src1_tag,
                   src2_ready, src2_value, src2_tag,
                   e.dr, e.r1, e.v1, e.t1, e.r2, e.v2, e.t2);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //   req dv we dst tg s1 s2 bv bt bd      fl dr  r1 v1      t1  r2 v2      t2
    step(1, 0, 0, 0, 0, 0, 7, 0, 0, 0,      0, 1,  1, 0,      0,  1, 0,      0); // R1 reset state
    step(7, 1, 1, 1, 5, 1, 1, 0, 0, 0,      0, 1,  1, 0,      0,  1, 0,      0); // R7 read before own rename
    step(3, 0, 0, 0, 0, 1, 2, 0, 0, 0,      0, 1,  0, 0,      5,  1, 0,      0); // R3 pending on tag 5
    step(7, 1, 1, 1, 9, 1, 0, 0, 0, 0,      0, 1,  0, 0,      5,  1, 0,      0); // R7 src equals dst
    step(5, 0, 0, 0, 0, 1, 0, 1, 5, 'h1111, 0, 1,  0, 0,      9,  1, 0,      0); // R5 stale tag 5
    step(5, 0, 0, 0, 0, 1, 0, 0, 0, 0,      0, 1,  0, 0,      9,  1, 0,      0); // R5 still pending on 9
    step(6, 0, 0, 0, 0, 1, 1, 1, 9, 'h2222, 0, 1,  1, 'h2222, 0,  1, 'h2222, 0); // R6 bypass
    step(4, 0, 0, 0, 0, 1, 0, 0, 0, 0,      0, 1,  1, 'h2222, 0,  1, 0,      0); // R4 written
    step(9, 1, 0, 1, 3, 1, 2, 0, 0, 0,      0, 1,  1, 'h2222, 0,  1, 0,      0); // R9 no write enable
    step(9, 0, 1, 2, 4, 1, 2, 0, 0, 0,      0, 1,  1, 'h2222, 0,  1, 0,      0); // R9 no valid
    step(9, 0, 0, 0, 0, 2, 1, 0, 0, 0,      0, 1,  1, 0,      0,  1, 'h2222, 0); // R9 nothing renamed
    step(3, 1, 1, 2, 6, 2, 0, 0, 0, 0,      0, 1,  1, 0,      0,  1, 0,      0); // R3 rename r2 to 6
    step(10,1, 1, 2, 7, 2, 0, 1, 6, 'h3333, 0, 1,  1, 'h3333, 0,  1, 0,      0); // R10 rename with old-tag result
    step(10,0, 0, 0, 0, 2, 0, 0, 0, 0,      0, 1,  0, 0,      7,  1, 0,      0); // R10 rename won
    step(3, 1, 1, 3, 8, 3, 2, 0, 0, 0,      0, 1,  1, 0,      0,  0, 0,      7); // R3 rename r3 to 8
    step(8, 1, 1, 4, 1, 2, 3, 1, 8, 'h4444, 1, 0,  0, 0,      7,  0, 0,      8); // R8 during flush
    step(8, 0, 0, 0, 0, 1, 3, 0, 0, 0,      0, 1,  1, 'h2222, 0,  1, 0,      0); // R8 after flush
    step(8, 0, 0, 0, 0, 4, 2, 0, 0, 0,      0, 1,  1, 0,      0,  1, 0,      0); // R8 no rename taken
    step(2, 0, 0, 0, 0, 1, 1, 0, 0, 0,      0, 1,  1, 'h2222, 0,  1, 'h2222, 0); // R2 ready read
    @(negedge clk);
    disp_valid = 1'b0;
    bc_valid   = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule